// File: doc/BRIEF.md
# Packed-Lane Media Arithmetic Unit

This is a pipelined functional unit for a wide-issue media datapath. It takes two 64-bit register operands and treats them as vectors of small integer lanes. It performs one of three media operations on them:

- a sum of absolute differences over eight unsigned byte lanes, reduced to a single scalar;
- a signed fractional multiply over four 16-bit lanes that keeps the rounded high part of each product;
- a rounded average over eight unsigned byte lanes, as used for half-pixel interpolation.

A new operation can be issued on every clock. Each one carries a valid bit and a guard bit. A result appears with its own valid flag exactly two cycles after issue.

The surrounding issue logic places operands, opcode, valid and guard on the inputs for one cycle. It then writes `res_o` back when `res_vld_o` is high. A false guard, or the reserved opcode, cancels the operation at issue, so no result is ever produced for it.

Top module: `simd_media_alu`

## Requirements
- R1: With opcode 0 (SAD), `res_o` equals the sum over the eight unsigned byte lanes of |a−b|. The sum is zero-extended, so bits 63:11 are zero and the value is at most 2040.
- R2: With opcode 1 (fractional multiply), each 16-bit lane k (bits 16k+15:16k) of `res_o` is floor((a_k·b_k + 16384) / 32768). Here a_k and b_k are signed two's-complement lanes.
- R3: In the fractional multiply, a lane value above 32767 is clamped to 0x7FFF. This happens only for −32768 × −32768. The value 0x8000 never appears in an output lane.
- R4: With opcode 2 (average), each byte lane k (bits 8k+7:8k) of `res_o` is (a_k + b_k + 1) >> 1. The operands are unsigned, the sum is taken at 9 bits, and ties round upward.
- R5: An operation issued with `valid_i`=1 and `guard_i`=1 and an opcode other than 3 produces `res_vld_o`=1 exactly two rising edges later. Operations issued on consecutive cycles give results on consecutive cycles, in issue order.
- R6: An operation issued with `guard_i`=0 produces no result. `res_vld_o` stays 0 in the cycle its result would have occupied.
- R7: Opcode 3 is reserved. It is treated like a false guard and produces no result.
- R8: Whenever `res_vld_o` is 0, `res_o` is all zeros.
- R9: While `rst_ni` is low, `res_vld_o` is 0 and `res_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Operation present this cycle |
| guard_i | input | 1 | Guard predicate; 0 cancels the operation |
| op_i | input | 2 | 0 SAD, 1 fractional multiply, 2 average, 3 reserved |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| res_vld_o | output | 1 | Result valid |
| res_o | output | 64 | Result, zero when not valid |

## Verification
The checker relates each result to the operands and opcode sampled two cycles earlier. It therefore assumes that inputs are stable from just after one rising edge until the next, and that the opcode is one of the four two-bit codes. The bench drives every input on the falling edge and issues each operation for exactly one cycle. It mixes back-to-back issue with idle gaps, false guards and the reserved opcode, so every pipeline occupancy pattern is legal input. Operand values range over full-scale extremes such as 0x00/0xFF bytes and ±32768 lanes, exact rounding ties, and uniformly random words.

// File: rtl/simd_media_pkg.sv
package simd_media_pkg;
  localparam int unsigned DATA_W     = 64;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned HALF_W     = 16;
  localparam int unsigned BYTE_LANES = DATA_W / BYTE_W;
  localparam int unsigned HALF_LANES = DATA_W / HALF_W;
  localparam int unsigned SAD_W      = BYTE_W + $clog2(BYTE_LANES);
  localparam int unsigned PROD_W     = 2 * HALF_W;
  localparam int unsigned FRAC_SH    = HALF_W - 1;

  typedef enum logic [1:0] {
    OP_SAD  = 2'd0,
    OP_MULH = 2'd1,
    OP_AVG  = 2'd2,
    OP_RSVD = 2'd3
  } media_op_e;
endpackage

// File: rtl/sad_unit.sv
module sad_unit
  import simd_media_pkg::*;
#(
  parameter int unsigned LANES  = BYTE_LANES,
  parameter int unsigned LANE_W = BYTE_W,
  localparam int unsigned SUM_W = LANE_W + $clog2(LANES)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic [LANES*LANE_W-1:0]   a_i,
  input  logic [LANES*LANE_W-1:0]   b_i,
  output logic [SUM_W-1:0]          sum_o
);
  logic [LANE_W-1:0] diff_q [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0] x, y;
    assign x = a_i[k*LANE_W +: LANE_W];
    assign y = b_i[k*LANE_W +: LANE_W];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   diff_q[k] <= '0;
      else if (en_i) diff_q[k] <= (x >= y) ? x - y : y - x;
    end
  end

  always_comb begin
    sum_o = '0;
    for (int k = 0; k < LANES; k++) sum_o = sum_o + SUM_W'(diff_q[k]);
  end
endmodule

// File: rtl/mulh_unit.sv
module mulh_unit
  import simd_media_pkg::*;
#(
  parameter int unsigned LANES  = HALF_LANES,
  parameter int unsigned LANE_W = HALF_W,
  localparam int unsigned P_W   = 2 * LANE_W,
  localparam int unsigned SH    = LANE_W - 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic [LANES*LANE_W-1:0]   a_i,
  input  logic [LANES*LANE_W-1:0]   b_i,
  output logic [LANES*LANE_W-1:0]   res_o
);
  localparam logic signed [P_W:0] RND    = (P_W+1)'(1) <<< (SH - 1);
  localparam logic signed [P_W:0] MAXPOS = (P_W+1)'((1 << (LANE_W - 1)) - 1);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic signed [P_W-1:0] prod_q;
    logic signed [P_W:0]   rnd;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   prod_q <= '0;
      else if (en_i) prod_q <= $signed(a_i[k*LANE_W +: LANE_W]) * $signed(b_i[k*LANE_W +: LANE_W]);
    end
    // extra bit keeps the rounding add from wrapping
    assign rnd = ($signed({prod_q[P_W-1], prod_q}) + RND) >>> SH;
    assign res_o[k*LANE_W +: LANE_W] = (rnd > MAXPOS) ? MAXPOS[LANE_W-1:0] : rnd[LANE_W-1:0];
  end
endmodule

// File: rtl/avg_unit.sv
module avg_unit
  import simd_media_pkg::*;
#(
  parameter int unsigned LANES  = BYTE_LANES,
  parameter int unsigned LANE_W = BYTE_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic [LANES*LANE_W-1:0]   a_i,
  input  logic [LANES*LANE_W-1:0]   b_i,
  output logic [LANES*LANE_W-1:0]   res_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W:0]   sum;
    logic [LANE_W-1:0] avg_q;
    assign sum = {1'b0, a_i[k*LANE_W +: LANE_W]} + {1'b0, b_i[k*LANE_W +: LANE_W]} + (LANE_W+1)'(1);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   avg_q <= '0;
      else if (en_i) avg_q <= sum[LANE_W:1];
    end
    assign res_o[k*LANE_W +: LANE_W] = avg_q;
  end
endmodule

// File: rtl/simd_media_alu.sv
module simd_media_alu
  import simd_media_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic              guard_i,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              res_vld_o,
  output logic [DATA_W-1:0] res_o
);
  media_op_e   op, s1_op_q;
  logic        issue, s1_vld_q;
  logic [SAD_W-1:0]  sad_sum;
  logic [DATA_W-1:0] mulh_res, avg_res, sel_res;

  assign op    = media_op_e'(op_i);
  assign issue = vld_i & guard_i & (op != OP_RSVD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q <= 1'b0;
      s1_op_q  <= OP_SAD;
    end else begin
      s1_vld_q <= issue;
      if (issue) s1_op_q <= op;
    end
  end

  sad_unit u_sad (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (issue && op == OP_SAD),
    .a_i (a_i), .b_i (b_i), .sum_o (sad_sum)
  );

  mulh_unit u_mulh (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (issue && op == OP_MULH),
    .a_i (a_i), .b_i (b_i), .res_o (mulh_res)
  );

  avg_unit u_avg (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (issue && op == OP_AVG),
    .a_i (a_i), .b_i (b_i), .res_o (avg_res)
  );

  always_comb begin
    unique case (s1_op_q)
      OP_SAD:  sel_res = DATA_W'(sad_sum);
      OP_MULH: sel_res = mulh_res;
      OP_AVG:  sel_res = avg_res;
      default: sel_res = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_vld_o <= 1'b0;
      res_o     <= '0;
    end else begin
      res_vld_o <= s1_vld_q;
      res_o     <= s1_vld_q ? sel_res : '0;
    end
  end
endmodule

// File: rtl/simd_media_alu_checker.sv
module simd_media_alu_checker
  import simd_media_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              vld_i,
  input logic              guard_i,
  input logic [1:0]        op_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic              res_vld_o,
  input logic [DATA_W-1:0] res_o
);
  AST_ISSUE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && guard_i && op_i != 2'd3) |-> ##2 res_vld_o); // R5

  AST_GUARD_CANCEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vld_i || !guard_i) |-> ##2 !res_vld_o); // R6

  AST_RSVD_CANCEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'd3) |-> ##2 !res_vld_o); // R7

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_vld_o |-> res_o == '0); // R8

  AST_SAD_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_vld_o && $past(op_i, 2) == 2'd0) |-> (res_o <= 64'd2040)); // R1

  for (genvar k = 0; k < HALF_LANES; k++) begin : g_h
    AST_NO_MIN_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (res_vld_o && $past(op_i, 2) == 2'd1) |-> res_o[k*HALF_W +: HALF_W] != 16'h8000); // R3
  end

  for (genvar k = 0; k < BYTE_LANES; k++) begin : g_b
    AST_AVG_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (res_vld_o && $past(op_i, 2) == 2'd2) |->
        (res_o[k*8 +: 8] >= (($past(a_i[k*8 +: 8], 2) < $past(b_i[k*8 +: 8], 2)) ? $past(a_i[k*8 +: 8], 2) : $past(b_i[k*8 +: 8], 2))) &&
        (res_o[k*8 +: 8] <= (($past(a_i[k*8 +: 8], 2) > $past(b_i[k*8 +: 8], 2)) ? $past(a_i[k*8 +: 8], 2) : $past(b_i[k*8 +: 8], 2)))); // R4
  end
endmodule

bind simd_media_alu simd_media_alu_checker u_chk (
  .clk_i (clk_i), .rst_ni (rst_ni), .vld_i (vld_i), .guard_i (guard_i), .op_i (op_i),
  .a_i (a_i), .b_i (b_i), .res_vld_o (res_vld_o), .res_o (res_o)
);

// File: tb/simd_media_alu_bench.sv
module simd_media_alu_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        vld_i = 1'b0, guard_i = 1'b0;
  logic [1:0]  op_i = 2'd0;
  logic [63:0] a_i = '0, b_i = '0;
  logic        res_vld_o;
  logic [63:0] res_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  typedef struct { logic [63:0] exp; string req; } item_t;
  item_t sbq[$];

  always #2ns clk_i = ~clk_i;  // 250 MHz

  simd_media_alu u_simd_media_alu (.*);

  function automatic logic [63:0] model(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r = '0;
    int s, x, y;
    longint p, q;
    case (op)
      2'd0: begin  // R1
        s = 0;
        for (int k = 0; k < 8; k++) begin
          x = int'(a[k*8 +: 8]); y = int'(b[k*8 +: 8]);
          s += (x > y) ? x - y : y - x;
        end
        r = 64'(s);
      end
      2'd1: for (int k = 0; k < 4; k++) begin  // R2, R3
        p = longint'($signed(a[k*16 +: 16])) * longint'($signed(b[k*16 +: 16]));
        q = (p + 16384) >>> 15;
        if (q > 32767) q = 32767;
        r[k*16 +: 16] = q[15:0];
      end
      2'd2: for (int k = 0; k < 8; k++) begin  // R4
        s = (int'(a[k*8 +: 8]) + int'(b[k*8 +: 8]) + 1) / 2;
        r[k*8 +: 8] = s[7:0];
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b,
                       input logic g, input string req);
    @(negedge clk_i);
    vld_i = 1'b1; guard_i = g; op_i = op; a_i = a; b_i = b;
    if (g && op != 2'd3) sbq.push_back('{model(op, a, b), req});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      vld_i = 1'b0; guard_i = 1'b0;
    end
  endtask

  // monitor / scoreboard
  initial begin
    item_t it;
    @(posedge rst_ni);
    forever begin
      @(negedge clk_i);
      if (res_vld_o) begin
        if (sbq.size() == 0) check("R6/R7 unexpected result", {63'd0, res_vld_o}, 64'd0);
        else begin
          it = sbq.pop_front();
          check(it.req, res_o, it.exp);
        end
      end else begin
        check("R8 idle output", res_o, 64'd0);
      end
    end
  end

  initial begin
    #400us;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R9 reset valid", {63'd0, res_vld_o}, 64'd0);
    check("R9 reset result", res_o, 64'd0);
    rst_ni = 1'b1;

    // R1 corners
    issue(2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, "R1 sad max");
    issue(2'd0, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 1'b1, "R1 sad equal");
    issue(2'd0, 64'h0010_FF00_0203_8070, 64'h1000_00FF_0302_7080, 1'b1, "R1 sad mixed");
    // R2/R3 corners
    issue(2'd1, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 1'b1, "R3 saturate");
    issue(2'd1, 64'h4000_0001_FFFF_8000, 64'h4000_4000_4000_7FFF, 1'b1, "R2 round ties");
    issue(2'd1, 64'h7FFF_8001_0003_FFFD, 64'h7FFF_7FFF_5555_5555, 1'b1, "R2 signs");
    // R4 corners
    issue(2'd2, 64'hFFFF_0100_8001_7F00, 64'hFEFF_0000_8180_8001, 1'b1, "R4 avg ties");
    idle(2);
    // R6/R7: cancelled ops between live ones, back to back (R5)
    issue(2'd2, 64'h0102_0304_0506_0708, 64'h0807_0605_0403_0201, 1'b1, "R5 b2b avg");
    issue(2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0, "R6 guard");
    issue(2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, "R7 rsvd");
    issue(2'd1, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 1'b1, "R5 b2b mulh");
    idle(4);

    // R5 exact latency: single op, observe two edges later
    issue(2'd0, 64'h00FF, 64'h0, 1'b1, "R5 latency");
    @(negedge clk_i); vld_i = 1'b0; guard_i = 1'b0;
    n_cmp++; if (res_vld_o !== 1'b0) begin n_bad++; $display("FAIL R5 early act=%b exp=0", res_vld_o); end
    @(negedge clk_i);
    n_cmp++; if (res_vld_o !== 1'b1) begin n_bad++; $display("FAIL R5 late act=%b exp=1", res_vld_o); end
    idle(3);

    // random mixed stream
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] a = {$urandom, $urandom};
      logic [63:0] b = {$urandom, $urandom};
      logic [1:0]  o = 2'($urandom);
      logic        g = ($urandom % 5) != 0;
      if (($urandom % 7) == 0) idle(1 + $urandom % 2);
      issue(o, a, b, g, o == 2'd0 ? "R1 rand" : o == 2'd1 ? "R2 rand" : o == 2'd2 ? "R4 rand" : "R7 rand");
    end
    idle(6);
    check("R5 drained", 64'(sbq.size()), 64'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule